// File: doc/BRIEF.md
# Keyed Watchdog Timer with Two-Stage Expiry

This block is a watchdog timer that counts a slow timebase tick down from a programmed interval. Firmware must restart it before the interval runs out. If it does not, the block raises a system reset. Every register write must carry a register-specific magic value, so a runaway or stray store cannot disarm or retune the timer. The timebase is a one-cycle enable pulse at the slow clock rate, and a fixed prescale turns the length field into ticks.

The block has an optional two-stage mode. The first expiry raises a level interrupt and starts the interval again. A second expiry with no restart in between then forces the reset. Software can also request an immediate reset with a keyed write. A board-level reset pin copies the internal reset pulse when it is enabled, and its active level is programmable.

The bus side is a simple single-cycle write strobe with a combinational read. Register offsets: control at 0x00, length at 0x04, restart at 0x08, software reset at 0x14.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the control register reads 0, the length register reads all ones in its count field (0x0000FFE0 with an 11-bit field), and irq and sys_rst are low. The reset pin is high, which is its inactive level when low polarity is selected.
- R2: A write to the length register (0x04) takes effect only when data bits [4:0] equal 0x08. The count is taken from bits starting at bit 5. A read returns the count at bit 5 upward and zeros in bits [4:0].
- R3: A write to the control register (0x00) takes effect only when data bits [31:24] equal 0x22. Stored bits: 0 run, 1 pin polarity (1 = active high), 2 pin enable, 3 interrupt enable, 4 auto-start, 6 two-stage. A read returns exactly those bits, with every other bit zero.
- R4: Only the exact word 0x00001971 written to 0x08 reloads the counter. Any other word there leaves the countdown untouched.
- R5: With run set and two-stage mode off, sys_rst rises after exactly length × PRESCALE ticks, counted from the write that started or reloaded the counter.
- R6: sys_rst stays high for exactly RST_PULSE ticks. On the tick that ends the pulse the counter reloads, and counting resumes.
- R7: With two-stage and interrupt enable both set, the first expiry raises irq and reloads the counter. The next expiry drops irq and raises sys_rst. With two-stage set but interrupt enable clear, the first expiry resets directly.
- R8: While irq is high, a valid restart write clears irq and reloads the full interval.
- R9: Clearing run freezes the countdown. Setting it again reloads the full interval, not the remainder.
- R10: Writing 0x00001209 to 0x14 raises sys_rst on the next cycle. Any other value there has no effect.
- R11: With pin enable set, ext_rst_pin shows sys_rst at the selected polarity. With pin enable clear, it stays at its inactive level.
- R12: The restart and software-reset registers read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase enable |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt from the first stage |
| sys_rst | output | 1 | Active-high reset pulse request |
| ext_rst_pin | output | 1 | Board reset pin, programmable polarity |

## Verification
The bench builds the block with PRESCALE=4 and RST_PULSE=3, keeps LEN_W at 11, and holds tick high. With these values a full two-stage sequence (warning, second expiry, reset pulse and restart) finishes in a few tens of cycles. Every interrupt and reset edge can then be predicted to the exact cycle and compared in a scoreboard. The large default length field still bounds the reset-value readback.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam logic [7:0]  OFS_MODE   = 8'h00;
  localparam logic [7:0]  OFS_LEN    = 8'h04;
  localparam logic [7:0]  OFS_KICK   = 8'h08;
  localparam logic [7:0]  OFS_SWRST  = 8'h14;
  localparam logic [7:0]  MODE_KEY   = 8'h22;
  localparam logic [4:0]  LEN_KEY    = 5'h08;
  localparam logic [31:0] KICK_WORD  = 32'h0000_1971;
  localparam logic [31:0] SWRST_WORD = 32'h0000_1209;
  localparam int          LEN_LSB    = 5;

  typedef struct packed {
    logic dual;
    logic autostart;
    logic irq_en;
    logic ext_en;
    logic pol_hi;
    logic en;
  } mode_t;

  typedef enum logic [1:0] {ST_RUN, ST_WARN, ST_RST} stage_t;

  function automatic logic mode_key_ok(input logic [31:0] w);
    return w[31:24] == MODE_KEY;
  endfunction

  function automatic logic len_key_ok(input logic [31:0] w);
    return w[4:0] == LEN_KEY;
  endfunction

  function automatic mode_t mode_from(input logic [31:0] w);
    mode_t m;
    m.dual      = w[6];
    m.autostart = w[4];
    m.irq_en    = w[3];
    m.ext_en    = w[2];
    m.pol_hi    = w[1];
    m.en        = w[0];
    return m;
  endfunction

  function automatic logic [31:0] mode_word(input mode_t m);
    return {25'd0, m.dual, 1'b0, m.autostart, m.irq_en, m.ext_en, m.pol_hi, m.en};
  endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              en_o,
  output logic              pol_hi_o,
  output logic              ext_en_o,
  output logic              warn_ok_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              kick_o,
  output logic              start_o,
  output logic              swrst_o
);

  mode_t            mode_q;
  logic [LEN_W-1:0] len_q;
  logic             hit_mode, hit_len, hit_kick, hit_swrst;
  logic             mode_ok, len_ok;

  assign hit_mode  = bus_wr && (bus_addr == ADDR_W'(OFS_MODE));
  assign hit_len   = bus_wr && (bus_addr == ADDR_W'(OFS_LEN));
  assign hit_kick  = bus_wr && (bus_addr == ADDR_W'(OFS_KICK));
  assign hit_swrst = bus_wr && (bus_addr == ADDR_W'(OFS_SWRST));

  assign mode_ok = hit_mode && mode_key_ok(bus_wdata);
  assign len_ok  = hit_len && len_key_ok(bus_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      len_q  <= '1;
    end else begin
      if (mode_ok) mode_q <= mode_from(bus_wdata);
      if (len_ok)  len_q  <= bus_wdata[LEN_LSB +: LEN_W];
    end
  end

  // event strobes, named so the checks below and the neighbours see them
  assign start_o = mode_ok && bus_wdata[0] && !mode_q.en;
  assign kick_o  = hit_kick && (bus_wdata == KICK_WORD);
  assign swrst_o = hit_swrst && (bus_wdata == SWRST_WORD);

  assign en_o      = mode_q.en;
  assign pol_hi_o  = mode_q.pol_hi;
  assign ext_en_o  = mode_q.ext_en;
  assign warn_ok_o = mode_q.dual && mode_q.irq_en;
  assign len_o     = len_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_MODE))
      bus_rdata = mode_word(mode_q);
    else if (bus_addr == ADDR_W'(OFS_LEN))
      bus_rdata = 32'(len_q) << LEN_LSB;
  end

  // R3: a control write without its key leaves the stored fields alone
  a_r3_mode_keyless_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mode && !mode_key_ok(bus_wdata)) |=> $stable(mode_q));

  // R2: a length write without its key leaves the count alone
  a_r2_len_keyless_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    (hit_len && !len_key_ok(bus_wdata)) |=> $stable(len_q));

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
  import kwdt_pkg::*;
#(
  parameter int LEN_W    = 11,
  parameter int PRESCALE = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             freeze,
  input  logic [LEN_W-1:0] len,
  input  logic             kick,
  input  logic             start,
  input  logic             done,
  output logic             expire_o
);

  localparam int PS_W  = $clog2(PRESCALE);
  localparam int CNT_W = LEN_W + PS_W;

  function automatic logic [CNT_W-1:0] ticks_for(input logic [LEN_W-1:0] units);
    return CNT_W'(units) * CNT_W'(PRESCALE);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             reload, step;

  assign reload   = done || ((kick || start) && !freeze);
  assign step     = en && tick && !freeze;
  assign expire_o = step && !reload && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= ticks_for('1);
    else if (reload || expire_o)
      cnt_q <= ticks_for(len);
    else if (step)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  // R9: with run clear and no reload request the countdown is frozen
  a_r9_hold_when_off : assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reload) |=> $stable(cnt_q));

endmodule

// File: rtl/kwdt_stage.sv
module kwdt_stage
  import kwdt_pkg::*;
#(
  parameter int RST_PULSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic expire,
  input  logic kick,
  input  logic sw_req,
  input  logic warn_ok,
  output logic irq_o,
  output logic sys_rst_o,
  output logic done_o
);

  localparam int PW = (RST_PULSE > 1) ? $clog2(RST_PULSE) : 1;

  stage_t        state_q;
  logic [PW-1:0] pcnt_q;

  assign done_o = (state_q == ST_RST) && tick && !sw_req && (pcnt_q == PW'(RST_PULSE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      pcnt_q  <= '0;
    end else if (sw_req) begin
      state_q <= ST_RST;
      pcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          pcnt_q <= '0;
          if (expire) state_q <= warn_ok ? ST_WARN : ST_RST;
        end
        ST_WARN: begin
          pcnt_q <= '0;
          if (expire)    state_q <= ST_RST;
          else if (kick) state_q <= ST_RUN;
        end
        ST_RST: begin
          if (done_o)    state_q <= ST_RUN;
          else if (tick) pcnt_q  <= pcnt_q + PW'(1);
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign irq_o     = (state_q == ST_WARN);
  assign sys_rst_o = (state_q == ST_RST);

  // R5: single-stage expiry goes straight to reset
  a_r5_single_stage_resets : assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !sys_rst_o && expire && !warn_ok && !sw_req) |=> sys_rst_o);

  // R7: first expiry in two-stage mode only warns
  a_r7_first_expiry_warns : assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !sys_rst_o && expire && warn_ok && !sw_req) |=> (irq_o && !sys_rst_o));

  // R7: second expiry while warned resets and drops the interrupt
  a_r7_second_expiry_resets : assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && expire) |=> (sys_rst_o && !irq_o));

  // R8: restart while warned clears the interrupt without a reset
  a_r8_kick_clears_irq : assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && kick && !expire && !sw_req) |=> (!irq_o && !sys_rst_o));

  // R10: software request resets on the next cycle
  a_r10_sw_reset : assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> sys_rst_o);

  // R6: the pulse ends only after its last tick was counted
  a_r6_pulse_len : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> ($past(pcnt_q) == PW'(RST_PULSE - 1)));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 11,
  parameter int PRESCALE  = 512,
  parameter int RST_PULSE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sys_rst,
  output logic              ext_rst_pin
);

  logic             run_en, pol_hi, ext_en, warn_ok;
  logic [LEN_W-1:0] len;
  logic             kick, start, sw_req, expire, done;

  kwdt_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .en_o     (run_en),
    .pol_hi_o (pol_hi),
    .ext_en_o (ext_en),
    .warn_ok_o(warn_ok),
    .len_o    (len),
    .kick_o   (kick),
    .start_o  (start),
    .swrst_o  (sw_req)
  );

  kwdt_count #(.LEN_W(LEN_W), .PRESCALE(PRESCALE)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .en      (run_en),
    .freeze  (sys_rst),
    .len     (len),
    .kick    (kick),
    .start   (start),
    .done    (done),
    .expire_o(expire)
  );

  kwdt_stage #(.RST_PULSE(RST_PULSE)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .expire   (expire),
    .kick     (kick),
    .sw_req   (sw_req),
    .warn_ok  (warn_ok),
    .irq_o    (irq),
    .sys_rst_o(sys_rst),
    .done_o   (done)
  );

  assign ext_rst_pin = (ext_en && sys_rst) ? pol_hi : !pol_hi;

endmodule

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;
  localparam int ADDR_W    = 8;
  localparam int LEN_W     = 11;
  localparam int PRESCALE  = 4;
  localparam int RST_PULSE = 3;

  localparam logic [7:0] A_MODE = 8'h00, A_LEN = 8'h04, A_KICK = 8'h08, A_SWRST = 8'h14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b1;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq, sys_rst, ext_rst_pin;

  kwdt_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PRESCALE(PRESCALE), .RST_PULSE(RST_PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sys_rst(sys_rst),
    .ext_rst_pin(ext_rst_pin)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    cyc;
    bit    sig;   // 0 = irq, 1 = sys_rst
    bit    val;
    string tag;
  } ev_t;

  ev_t  expq[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  int   c0 = 0;
  bit   mon_on = 1'b0;
  bit   finished = 1'b0;
  logic prev_irq = 1'b0, prev_rst = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic note(input bit s, input bit v);
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL R5/R7/R9: unexpected %s=%0b at cycle %0d, expected no edge",
               s ? "sys_rst" : "irq", v, cyc);
    end else begin
      ev_t e;
      e = expq.pop_front();
      if (e.sig != s || e.val != v || e.cyc != cyc) begin
        errors++;
        $display("FAIL %s: got %s=%0b at cycle %0d, expected %s=%0b at cycle %0d",
                 e.tag, s ? "sys_rst" : "irq", v, cyc, e.sig ? "sys_rst" : "irq", e.val, e.cyc);
      end
    end
  endtask

  // monitor: records every output edge and scores it against the queue
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (mon_on) begin
        if (irq !== prev_irq) note(1'b0, irq);
        if (sys_rst !== prev_rst) note(1'b1, sys_rst);
      end
      prev_irq = irq;
      prev_rst = sys_rst;
    end
  end

  task automatic expect_ev(input bit s, input bit v, input int off, input string tag);
    ev_t e;
    e.cyc = c0 + off;
    e.sig = s;
    e.val = v;
    e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic wr_begin(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    c0 = cyc + 1;
  endtask

  task automatic wr_end();
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_begin(a, d);
    wr_end();
  endtask

  task automatic drain(input int n, input string tag);
    repeat (n) @(negedge clk);
    checks++;
    while (expq.size() > 0) begin
      ev_t e;
      e = expq.pop_front();
      errors++;
      $display("FAIL %s: missing %s=%0b, expected at cycle %0d (now %0d)",
               e.tag, e.sig ? "sys_rst" : "irq", e.val, e.cyc, cyc);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    rd_chk(A_MODE, 32'h0, "R1 mode");
    rd_chk(A_LEN, 32'h0000_FFE0, "R1 length");
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 sys_rst", 32'(sys_rst), 32'h0);
    chk("R1 pin", 32'(ext_rst_pin), 32'h1);

    // R12 restart and software-reset registers read zero
    rd_chk(A_KICK, 32'h0, "R12 restart reg");
    rd_chk(A_SWRST, 32'h0, "R12 swrst reg");

    // R2 length key
    wr(A_LEN, (32'd5 << 5) | 32'h07);
    rd_chk(A_LEN, 32'h0000_FFE0, "R2 keyless length ignored");
    wr(A_LEN, (32'd3 << 5) | 32'h08);
    rd_chk(A_LEN, 32'h0000_0060, "R2 keyed length");

    // R3 control key and readback
    wr(A_MODE, 32'h2100_005E);
    rd_chk(A_MODE, 32'h0, "R3 keyless mode ignored");
    wr(A_MODE, 32'h2200_007E);
    rd_chk(A_MODE, 32'h0000_005E, "R3 mode readback");
    chk("R11 idle pin active-high", 32'(ext_rst_pin), 32'h0);
    wr(A_MODE, 32'h2200_0000);

    // R5/R6 single stage: length 3 -> 12 ticks, pulse 3 ticks
    wr_begin(A_MODE, 32'h2200_0001);
    expect_ev(1'b1, 1'b1, 12, "R5");
    expect_ev(1'b1, 1'b0, 12 + RST_PULSE, "R6");
    wr_end();
    drain(16, "R6");
    wr(A_MODE, 32'h2200_0000);

    // R4 wrong restart word does not reload
    wr_begin(A_MODE, 32'h2200_0001);
    expect_ev(1'b1, 1'b1, 12, "R4 bad word");
    expect_ev(1'b1, 1'b0, 12 + RST_PULSE, "R4 bad word");
    wr_end();
    repeat (3) @(negedge clk);
    wr(A_KICK, 32'h0000_1970);
    drain(12, "R4 bad word");
    wr(A_MODE, 32'h2200_0000);

    // R4 correct restart word reloads
    wr(A_MODE, 32'h2200_0001);
    repeat (5) @(negedge clk);
    wr_begin(A_KICK, 32'h0000_1971);
    expect_ev(1'b1, 1'b1, 12, "R4 kick");
    expect_ev(1'b1, 1'b0, 12 + RST_PULSE, "R4 kick");
    wr_end();
    drain(16, "R4 kick");
    wr(A_MODE, 32'h2200_0000);

    // R7 two-stage: length 2 -> 8 ticks
    wr(A_LEN, (32'd2 << 5) | 32'h08);
    wr_begin(A_MODE, 32'h2200_0049);
    expect_ev(1'b0, 1'b1, 8, "R7 warn");
    expect_ev(1'b0, 1'b0, 16, "R7 irq drop");
    expect_ev(1'b1, 1'b1, 16, "R7 second expiry");
    expect_ev(1'b1, 1'b0, 16 + RST_PULSE, "R7 pulse end");
    wr_end();
    drain(20, "R7");
    wr(A_MODE, 32'h2200_0000);

    // R7 two-stage without interrupt enable resets at first expiry
    wr_begin(A_MODE, 32'h2200_0041);
    expect_ev(1'b1, 1'b1, 8, "R7 no irq_en");
    expect_ev(1'b1, 1'b0, 8 + RST_PULSE, "R7 no irq_en");
    wr_end();
    drain(12, "R7 no irq_en");
    wr(A_MODE, 32'h2200_0000);

    // R8 restart during warning
    wr_begin(A_MODE, 32'h2200_0049);
    expect_ev(1'b0, 1'b1, 8, "R8 warn");
    wr_end();
    wait_to(c0 + 10);
    wr_begin(A_KICK, 32'h0000_1971);
    expect_ev(1'b0, 1'b0, 0, "R8 irq cleared");
    expect_ev(1'b0, 1'b1, 8, "R8 full reload");
    wr_end();
    drain(8, "R8");
    wr(A_MODE, 32'h2200_0000);
    wr_begin(A_KICK, 32'h0000_1971);
    expect_ev(1'b0, 1'b0, 0, "R8 irq cleared");
    wr_end();
    drain(3, "R8");

    // R9 disable freezes, re-enable reloads the full interval
    wr(A_MODE, 32'h2200_0001);
    repeat (3) @(negedge clk);
    wr(A_MODE, 32'h2200_0000);
    drain(30, "R9 frozen");
    wr_begin(A_MODE, 32'h2200_0001);
    expect_ev(1'b1, 1'b1, 8, "R9 reload");
    expect_ev(1'b1, 1'b0, 8 + RST_PULSE, "R9 reload");
    wr_end();
    drain(12, "R9");
    wr(A_MODE, 32'h2200_0000);

    // R10 software reset
    wr(A_SWRST, 32'h0000_1208);
    drain(5, "R10 wrong value");
    wr_begin(A_SWRST, 32'h0000_1209);
    expect_ev(1'b1, 1'b1, 0, "R10");
    expect_ev(1'b1, 1'b0, RST_PULSE, "R10");
    wr_end();
    chk("R11 pin disabled", 32'(ext_rst_pin), 32'h1);
    drain(5, "R10");

    // R11 active-high pin
    wr(A_MODE, 32'h2200_0006);
    chk("R11 high idle", 32'(ext_rst_pin), 32'h0);
    wr_begin(A_SWRST, 32'h0000_1209);
    expect_ev(1'b1, 1'b1, 0, "R11 high");
    expect_ev(1'b1, 1'b0, RST_PULSE, "R11 high");
    wr_end();
    chk("R11 high asserted", 32'(ext_rst_pin), 32'h1);
    drain(5, "R11 high");

    // R11 active-low pin
    wr(A_MODE, 32'h2200_0004);
    chk("R11 low idle", 32'(ext_rst_pin), 32'h1);
    wr_begin(A_SWRST, 32'h0000_1209);
    expect_ev(1'b1, 1'b1, 0, "R11 low");
    expect_ev(1'b1, 1'b0, RST_PULSE, "R11 low");
    wr_end();
    chk("R11 low asserted", 32'(ext_rst_pin), 32'h0);
    drain(5, "R11 low");
    wr(A_MODE, 32'h2200_0000);

    drain(4, "final");
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

endmodule